// File: doc/BRIEF.md
# Windowed Watchdog Timer

This peripheral watches software timing from both sides. A 7-bit down-counter is stepped by a divider chain on the peripheral clock. The chain has a fixed power-of-two stage followed by a selectable extra division of 1, 2, 4 or 8. Once software has armed the watchdog, a reset request goes out when the counter falls out of its valid range, meaning bit 6 clears. A reset request also goes out when software reloads the counter too early, while the count is still above a programmed window value. A warning flag, and an optional interrupt, mark the last count before the reset point.

Software reaches the block through a simple strobe interface with three word registers. The reset request is a one-cycle registered pulse for the system reset controller. That controller sits outside this block. The arming bit and the interrupt enable can only be turned off by a reset.

Top module: `win_wdog`

## Requirements
- R1: After reset, CTRL reads 0x7F (counter 0x7F, not armed), CFG reads 0x7F (window 0x7F, prescale 0, interrupt enable 0), STAT reads 0, and both outputs are low.
- R2: Registers are selected by `reg_addr`. Address 0 is CTRL: [6:0] is the live counter and [7] is the armed bit. Address 1 is CFG: [6:0] window, [8:7] prescale select, [9] interrupt enable. Address 2 is STAT: [0] warning flag. All other bits and addresses read 0.
- R3: The counter decrements once every 2^(FIXED_LOG2+sel) clocks, where sel is 0..3. The divider restarts on every CTRL write, so the first decrement lands 2^(FIXED_LOG2+sel) clocks after the write edge. The counter wraps from 0x00 to 0x7F. A CTRL write loads CTRL[6:0] into the counter.
- R4: Writing 1 to CTRL[7] arms the watchdog. Writing 0 to CTRL[7] leaves it armed.
- R5: While armed, a decrement from 0x40 to 0x3F raises `rst_req_o`.
- R6: A CTRL write with bit 6 = 0 raises `rst_req_o` if the watchdog is armed, or if the same write arms it.
- R7: A CTRL write made while already armed raises `rst_req_o` if the counter is above the window value. When the counter is at or below the window value, no reset is requested. In both cases the counter is loaded.
- R8: `rst_req_o` never rises while the watchdog is not armed.
- R9: The warning flag STAT[0] is set by the decrement that brings the counter to 0x40, whether or not the interrupt is enabled.
- R10: Writing STAT[0] = 0 clears the warning flag. Writing STAT[0] = 1 leaves it unchanged.
- R11: The interrupt enable CFG[9] cannot be cleared by a write. `irq_o` is high exactly while both the enable and the warning flag are 1.
- R12: `rst_req_o` is registered. It is high for one clock, in the cycle after the edge that follows the triggering condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| rst_req_o | output | 1 | One-cycle system reset request |
| irq_o | output | 1 | Early-warning interrupt |

## Verification
The counting path is tried with every prescale select, using several load values. One of these loads wraps through zero and one crosses 0x40 while the watchdog is not armed. Together these separate a wrong divide ratio, a wrong load, a broken wrap, and a reset that leaks out while the watchdog is not armed. Directed sequences then try the other paths. One reloads above the window and one reloads below it, which tells the window comparison apart from the bit-6 check. Another writes a low counter value with the window opened fully. A further sequence runs the counter down to 0x40 and then 0x3F to time the flag, the interrupt and the pulse edge. The last writes 0 to the sticky bits and writes 1 to the flag.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int CNT_W = 7;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CFG  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  localparam logic [CNT_W-1:0] CNT_INIT = 7'h7F;
  localparam logic [CNT_W-1:0] WIN_INIT = 7'h7F;
  localparam logic [CNT_W-1:0] WARN_VAL = 7'h40;

  // divider output fires when the low 'bits' bits of the free count are all ones
  function automatic logic tick_due(input logic [31:0] cnt, input int unsigned bits);
    logic [31:0] mask;
    mask = (32'd1 << bits) - 32'd1;
    return (cnt & mask) == mask;
  endfunction

  // a reload is bad if it leaves bit 6 low on an armed dog,
  // or if it arrives before the counter has dropped to the window
  function automatic logic reload_bad(input logic armed_before,
                                      input logic armed_after,
                                      input logic [CNT_W-1:0] new_val,
                                      input logic [CNT_W-1:0] cur_val,
                                      input logic [CNT_W-1:0] window);
    return (armed_after && !new_val[CNT_W-1]) || (armed_before && (cur_val > window));
  endfunction

endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int FIXED_LOG2 = 12,
  parameter int SEL_W      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  import wdog_pkg::*;

  localparam int PW = FIXED_LOG2 + (1 << SEL_W) - 1;

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_q <= '0;
    else if (restart) pre_q <= '0;
    else              pre_q <= pre_q + 1'b1;
  end

  always_comb tick = tick_due(32'(pre_q), FIXED_LOG2 + int'(sel));

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [wdog_pkg::CNT_W-1:0] load_val,
  input  logic                       tick,
  output logic [wdog_pkg::CNT_W-1:0] cnt,
  output logic                       warn_evt,
  output logic                       drop_evt
);
  import wdog_pkg::*;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= CNT_INIT;
    else if (load) cnt_q <= load_val;
    else if (tick) cnt_q <= cnt_q - 1'b1;
  end

  always_comb begin
    cnt      = cnt_q;
    warn_evt = tick && !load && (cnt_q == WARN_VAL + 7'd1);
    drop_evt = tick && !load && (cnt_q == WARN_VAL);
  end

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs #(
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [1:0]                 addr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [wdog_pkg::CNT_W-1:0] cnt,
  input  logic                       warn_evt,
  input  logic                       drop_evt,
  output logic [DATA_W-1:0]          rdata,
  output logic                       ctrl_wr,
  output logic [1:0]                 sel,
  output logic                       armed,
  output logic                       ewif,
  output logic                       ewi,
  output logic                       rst_req,
  output logic                       irq
);
  import wdog_pkg::*;

  logic             armed_q, ewi_q, ewif_q, rst_q;
  logic [CNT_W-1:0] win_q;
  logic [1:0]       sel_q;
  logic             cfg_wr, stat_wr, armed_nx, trig;

  always_comb begin
    ctrl_wr  = wr && (addr == A_CTRL);
    cfg_wr   = wr && (addr == A_CFG);
    stat_wr  = wr && (addr == A_STAT);
    armed_nx = armed_q | (ctrl_wr & wdata[CNT_W]);
    trig     = (ctrl_wr && reload_bad(armed_q, armed_nx, wdata[CNT_W-1:0], cnt, win_q))
             || (armed_q && drop_evt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      win_q   <= WIN_INIT;
      sel_q   <= 2'd0;
      ewi_q   <= 1'b0;
      ewif_q  <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      armed_q <= armed_nx;
      rst_q   <= trig;
      if (cfg_wr) begin
        win_q <= wdata[CNT_W-1:0];
        sel_q <= wdata[8:7];
        ewi_q <= ewi_q | wdata[9];
      end
      if (warn_evt)                 ewif_q <= 1'b1;
      else if (stat_wr && !wdata[0]) ewif_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata[CNT_W:0] = {armed_q, cnt};
      A_CFG:   rdata[9:0]     = {ewi_q, sel_q, win_q};
      A_STAT:  rdata[0]       = ewif_q;
      default: rdata          = '0;
    endcase
    sel     = sel_q;
    armed   = armed_q;
    ewif    = ewif_q;
    ewi     = ewi_q;
    rst_req = rst_q;
    irq     = ewi_q & ewif_q;
  end

endmodule

// File: rtl/win_wdog.sv
module win_wdog #(
  parameter int FIXED_LOG2 = 12,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              rst_req_o,
  output logic              irq_o
);
  import wdog_pkg::*;

  logic             tick_w, ctrl_wr_w, warn_w, drop_w;
  logic             armed_w, ewif_w, ewi_w;
  logic [1:0]       sel_w;
  logic [CNT_W-1:0] cnt_w;

  wdog_prescale #(.FIXED_LOG2(FIXED_LOG2), .SEL_W(2)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(ctrl_wr_w), .sel(sel_w), .tick(tick_w)
  );

  wdog_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .load(ctrl_wr_w), .load_val(reg_wdata[CNT_W-1:0]),
    .tick(tick_w), .cnt(cnt_w), .warn_evt(warn_w), .drop_evt(drop_w)
  );

  wdog_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .cnt(cnt_w), .warn_evt(warn_w), .drop_evt(drop_w), .rdata(reg_rdata),
    .ctrl_wr(ctrl_wr_w), .sel(sel_w), .armed(armed_w), .ewif(ewif_w), .ewi(ewi_w),
    .rst_req(rst_req_o), .irq(irq_o)
  );

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       armed,
  input logic       ewi,
  input logic       ewif,
  input logic       tick,
  input logic       ctrl_wr,
  input logic [6:0] cnt,
  input logic       rst_req
);

  // R4
  armed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) armed |=> armed);

  // R11
  ewi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) ewi |=> ewi);

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_wr && !tick) |=> $stable(cnt));

  // R9
  warn_at_40_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ewif) |-> (cnt == 7'h40));

  // R5
  drop_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && tick && !ctrl_wr && cnt == 7'h40) |=> rst_req);

  // R8
  rst_armed_chk: assert property (@(posedge clk) disable iff (!rst_n) rst_req |-> armed);

endmodule

bind win_wdog wdog_chk chk_i (
  .clk(clk), .rst_n(rst_n), .armed(armed_w), .ewi(ewi_w), .ewif(ewif_w),
  .tick(tick_w), .ctrl_wr(ctrl_wr_w), .cnt(cnt_w), .rst_req(rst_req_o)
);

// File: tb/win_wdog_tb_top.sv
module win_wdog_tb_top;

  localparam int FL2 = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rst_req_o, irq_o;

  int n_chk = 0;
  int n_bad = 0;
  int rst_seen = 0;

  always #5 clk = ~clk;

  win_wdog #(.FIXED_LOG2(FL2), .DATA_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rst_req_o(rst_req_o), .irq_o(irq_o)
  );

  always @(negedge clk) if (rst_req_o) rst_seen++;

  // {sel, load, ticks}
  typedef struct packed { logic [1:0] sel; logic [6:0] load; logic [7:0] ticks; } vec_t;
  localparam vec_t VECS [6] = '{
    '{2'd0, 7'h7F, 8'd3}, '{2'd1, 7'h60, 8'd5}, '{2'd2, 7'h45, 8'd7},
    '{2'd3, 7'h42, 8'd4}, '{2'd0, 7'h05, 8'd9}, '{2'd3, 7'h7F, 8'd2}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic run_ticks(input int n, input int per);
    repeat (n * per) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, d); chk("R1 ctrl", d, 32'h7F);
    rd(2'd1, d); chk("R1 cfg", d, 32'h7F);
    rd(2'd2, d); chk("R1 stat", d, 32'h0);
    rd(2'd3, d); chk("R2 unused addr", d, 32'h0);
    chk("R1 outputs", {30'd0, rst_req_o, irq_o}, 32'h0);

    // R3 count vectors, disarmed (R8)
    foreach (VECS[i]) begin
      int per;
      per = 1 << (FL2 + int'(VECS[i].sel));
      wr(2'd1, 32'h7F | (32'(VECS[i].sel) << 7));
      wr(2'd0, 32'(VECS[i].load));
      chk("R8 no pulse when disarmed", {31'd0, rst_req_o}, 32'h0);
      run_ticks(int'(VECS[i].ticks), per);
      rd(2'd0, d);
      chk("R3 count/prescale", d, 32'((VECS[i].load - VECS[i].ticks[6:0]) & 7'h7F));
    end
    chk("R8 no reset seen while disarmed", rst_seen, 0);

    // flag set while disarmed with irq disabled: R9
    rd(2'd2, d); chk("R9 flag without irq enable", d, 32'h1);
    chk("R11 irq low without enable", {31'd0, irq_o}, 32'h0);
    wr(2'd2, 32'h0);
    rd(2'd2, d); chk("R10 clear by 0", d, 32'h0);

    // window 0x50, sel 0, irq enable
    wr(2'd1, 32'h50 | (32'h1 << 9));
    rd(2'd1, d); chk("R2 cfg readback", d, 32'h250);
    wr(2'd0, 32'hFF);
    chk("R4 arming write no pulse", {31'd0, rst_req_o}, 32'h0);
    rd(2'd0, d); chk("R4 armed readback", d, 32'hFF);

    // early reload, counter 0x7F > 0x50
    wr(2'd0, 32'h70);
    chk("R7 early reload pulse", {31'd0, rst_req_o}, 32'h1);
    @(negedge clk);
    chk("R12 pulse one cycle", {31'd0, rst_req_o}, 32'h0);
    rd(2'd0, d); chk("R4 armed stays, R7 loaded", d, 32'hF0);

    // legal reload after dropping below window
    run_ticks(40, 4);
    wr(2'd0, 32'h7F);
    chk("R7 in-window reload no pulse", {31'd0, rst_req_o}, 32'h0);

    // bit-6-low write with window fully open
    wr(2'd1, 32'h7F | (32'h1 << 9));
    wr(2'd0, 32'h3F);
    chk("R6 low write pulse", {31'd0, rst_req_o}, 32'h1);
    wr(2'd0, 32'h7F);
    chk("R6 restore no pulse", {31'd0, rst_req_o}, 32'h0);

    // run down to 0x41, 0x40, 0x3F
    run_ticks(62, 4);
    rd(2'd0, d); chk("R3 at 0x41", d, 32'hC1);
    chk("R11 irq before warn", {31'd0, irq_o}, 32'h0);
    run_ticks(1, 4);
    rd(2'd2, d); chk("R9 flag at 0x40", d, 32'h1);
    chk("R11 irq at 0x40", {31'd0, irq_o}, 32'h1);
    chk("R5 no pulse at 0x40", {31'd0, rst_req_o}, 32'h0);
    run_ticks(1, 4);
    chk("R5 underflow pulse", {31'd0, rst_req_o}, 32'h1);
    @(negedge clk);
    chk("R12 underflow pulse width", {31'd0, rst_req_o}, 32'h0);

    // flag write semantics
    wr(2'd2, 32'h1);
    rd(2'd2, d); chk("R10 write 1 no effect", d, 32'h1);
    chk("R11 irq held", {31'd0, irq_o}, 32'h1);
    wr(2'd2, 32'h0);
    rd(2'd2, d); chk("R10 write 0 clears", d, 32'h0);
    chk("R11 irq drops", {31'd0, irq_o}, 32'h0);

    // sticky enable
    wr(2'd1, 32'h7F);
    rd(2'd1, d); chk("R11 enable sticky", d, 32'h27F);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule